// File: doc/BRIEF.md
# Multi-device start synchronizer

This block decides when a sample-processing pipeline leaves its idle state, and makes several devices do so on the same clock edge. A start request can arrive as an asynchronous active-low level on `start_req_n`. The block passes that level through a flop chain clocked by the input clock and finds its high-to-low transition. For each such transition it drives a single-cycle pulse on `start_out`.

The block also accepts a start that is already synchronous, on `sync_start`. A second device can have its `sync_start` driven by the first device's `start_out`, with its own `start_req_n` tied high. Either source moves the block into operating mode, which `running` shows. Once set, operating mode stays set until reset. The pipeline takes input samples from the cycle after `running` rises, which `sample_take` shows.

The asynchronous path does not set `running` while the pulse is being generated. It sets `running` on the edge after `start_out` rises. This is the same edge on which a device fed by that pulse starts, so a master and its followers start together.

Top module: `start_sync_ctrl`

## Requirements
- R1: When `start_req_n` is first sampled low at edge k, after being high, `start_out` is high for exactly one cycle: the cycle after edge k+SYNC_STAGES. SYNC_STAGES is 2 by default.
- R2: Each high-to-low transition of `start_req_n` gives exactly one `start_out` pulse. Holding `start_req_n` low gives no further pulse. Returning it high and then low again gives another pulse.
- R3: `rst` is synchronous and active high. After any edge at which `rst` is high, `start_out`, `running` and `sample_take` are 0. While `rst` is high, `start_req_n` and `sync_start` have no effect, and the synchronizer holds the request as idle (high).
- R4: If `sync_start` is 1 at an edge outside reset, `running` is 1 after that edge.
- R5: A request on `start_req_n` sets `running` on the edge after the one at which `start_out` rises.
- R6: Once `running` is 1, it stays 1 until an edge with `rst` high.
- R7: `sample_take` equals the value `running` held in the previous cycle, so samples are taken from the cycle after the start.
- R8: Take a second instance whose `sync_start` is the first instance's `start_out` and whose `start_req_n` is tied high. Its `running` rises on the same edge as the first instance's `running`.
- R9: After reset, with `start_req_n` held high and `sync_start` held 0, `running` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input sample clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req_n | input | 1 | Asynchronous start request, active low |
| sync_start | input | 1 | Synchronous start, active high |
| start_out | output | 1 | One-cycle start pulse, used to chain other devices |
| running | output | 1 | Operating-mode flag |
| sample_take | output | 1 | High from the cycle after the start; input samples are valid |

## Verification
The bench drives the request low while reset is held and pulses `sync_start` during reset. A design that let either through would leave reset already running, or would emit a pulse on release. It then holds the request low for many cycles. A level detector in place of an edge detector would produce a wide or repeated `start_out`. A synchronizer of the wrong length shifts the pulse by a cycle, and the cycle-by-cycle reference model catches that.

A chained second instance is compared edge by edge with the first. If the asynchronous path set `running` together with the pulse, the two devices would start one cycle apart. Finally, the bench starts through `sync_start` alone and applies a second request after start. This checks that the synchronous path works without the pulse and that operating mode never drops.

// File: rtl/start_sync_pkg.sv
package start_sync_pkg;

    // Shortest flop chain accepted for the asynchronous request.
    localparam int MIN_SYNC_STAGES = 2;

    // Idle level of the active-low request.
    localparam logic REQ_IDLE = 1'b1;

    typedef enum logic {
        MODE_IDLE = 1'b0,
        MODE_RUN  = 1'b1
    } mode_e;

    typedef struct packed {
        logic run;
        logic take;
    } mode_out_t;

    // High-to-low transition between two successive samples.
    function automatic logic fell(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

    // Clamp a requested synchronizer depth to the legal minimum.
    function automatic int legal_stages(input int req);
        return (req < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : req;
    endfunction

endpackage

// File: rtl/sss_sync_chain.sv
module sss_sync_chain
    import start_sync_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int DEPTH = legal_stages(STAGES);

    logic [DEPTH-1:0] chain;

    // Every stage resets to the idle level, so leaving reset never looks like a request.
    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= REQ_IDLE;
                    else     chain[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= REQ_IDLE;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[DEPTH-1];

endmodule

// File: rtl/sss_pulse_gen.sv
module sss_pulse_gen
    import start_sync_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic pulse
);
    logic lvl_prev;
    logic fire;

    assign fire = fell(lvl_prev, lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_prev <= REQ_IDLE;
            pulse    <= 1'b0;
        end else begin
            lvl_prev <= lvl;
            pulse    <= fire;
        end
    end

endmodule

// File: rtl/sss_mode_latch.sv
module sss_mode_latch
    import start_sync_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_pulse,
    input  logic      sync_start,
    output mode_out_t state
);
    mode_e mode_q;
    mode_e mode_d;
    logic  take_q;
    logic  trigger;

    // The registered pulse is the asynchronous path's trigger. It therefore lands on
    // the same edge as a follower device fed by that pulse.
    assign trigger = req_pulse | sync_start;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_IDLE: if (trigger) mode_d = MODE_RUN;
            MODE_RUN:  mode_d = MODE_RUN;
            default:   mode_d = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_IDLE;
            take_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            take_q <= (mode_q == MODE_RUN);
        end
    end

    assign state.run  = (mode_q == MODE_RUN);
    assign state.take = take_q;

endmodule

// File: rtl/start_sync_ctrl.sv
module start_sync_ctrl
    import start_sync_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_req_n,
    input  logic sync_start,
    output logic start_out,
    output logic running,
    output logic sample_take
);
    logic      req_synced;
    mode_out_t mode_st;

    sss_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (start_req_n),
        .q   (req_synced)
    );

    sss_pulse_gen u_pulse (
        .clk   (clk),
        .rst   (rst),
        .lvl   (req_synced),
        .pulse (start_out)
    );

    sss_mode_latch u_mode (
        .clk        (clk),
        .rst        (rst),
        .req_pulse  (start_out),
        .sync_start (sync_start),
        .state      (mode_st)
    );

    assign running     = mode_st.run;
    assign sample_take = mode_st.take;

endmodule

// File: rtl/start_sync_ctrl_chk.sv
module start_sync_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic sync_start,
    input logic start_out,
    input logic running,
    input logic sample_take
);
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst) start_out |=> !start_out); // R1
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!running && !start_out && !sample_take)); // R3
    AST_SYNC_START_RUNS: assert property (@(posedge clk) disable iff (rst) sync_start |=> running); // R4
    AST_PULSE_THEN_RUN: assert property (@(posedge clk) disable iff (rst) start_out |=> running); // R5
    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst) running |=> running); // R6
    AST_TAKE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst) running |=> sample_take); // R7
    AST_NO_TAKE_IDLE: assert property (@(posedge clk) disable iff (rst) !running |=> !sample_take); // R7
    AST_NO_SPONTANEOUS_RUN: assert property (@(posedge clk) disable iff (rst)
        (!running && !start_out && !sync_start) |=> !running); // R9
endmodule

bind start_sync_ctrl start_sync_ctrl_chk u_chk (.*);

// File: tb/sim_start_sync_ctrl.sv
`timescale 1ns/1ps
module sim_start_sync_ctrl;
    localparam int N = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_n = 1'b1;
    logic sync_a = 1'b0;
    logic a_out, a_run, a_take;
    logic b_out, b_run, b_take;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int pulse_cnt = 0;
    string phase = "R3";

    always #2 clk = ~clk;

    start_sync_ctrl #(.SYNC_STAGES(N)) u0 (
        .clk(clk), .rst(rst), .start_req_n(req_n), .sync_start(sync_a),
        .start_out(a_out), .running(a_run), .sample_take(a_take)
    );

    // Follower: chained on the first instance's start pulse.
    start_sync_ctrl #(.SYNC_STAGES(N)) u1 (
        .clk(clk), .rst(rst), .start_req_n(1'b1), .sync_start(a_out),
        .start_out(b_out), .running(b_run), .sample_take(b_take)
    );

    // Behavioural reference model.
    int   hist[$];
    logic m_pulse = 0, m_run = 0, m_take = 0, mb_run = 0, mb_take = 0;

    always @(posedge clk) begin
        logic np, nr, nt, nbr, nbt;
        cycles++;
        if (rst) begin
            hist = {};
            for (int i = 0; i < N + 2; i++) hist.push_back(1);
            m_pulse = 0; m_run = 0; m_take = 0; mb_run = 0; mb_take = 0;
        end else begin
            hist.push_front(int'(req_n));
            void'(hist.pop_back());
            np  = (hist[N+1] == 1) && (hist[N] == 0);
            nr  = m_run | m_pulse | sync_a;
            nt  = m_run;
            nbr = mb_run | m_pulse;
            nbt = mb_run;
            m_pulse = np; m_run = nr; m_take = nt; mb_run = nbr; mb_take = nbt;
        end
    end

    task automatic check1(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", phase, what, act, exp, cycles);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check1("start_out", a_out, m_pulse);
        check1("running", a_run, m_run);
        check1("sample_take", a_take, m_take);
        check1("follower running", b_run, mb_run);
        check1("follower sample_take", b_take, mb_take);
        check1("follower start_out", b_out, 1'b0);
        if (a_out === 1'b1) pulse_cnt++;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        // R3: inputs toggled while reset is held are ignored.
        phase = "R3";
        ticks(2);
        req_n = 1'b0; sync_a = 1'b1; ticks(2);
        req_n = 1'b1; sync_a = 1'b0; ticks(2);
        // R9: idle after reset.
        phase = "R9";
        rst = 1'b0;
        ticks(8);
        // R1 R5 R7 R8: asynchronous start, master and follower together.
        phase = "R1 R5 R7 R8";
        pulse_cnt = 0;
        req_n = 1'b0;
        ticks(6);
        // R2: held low gives no further pulse.
        phase = "R2";
        ticks(20);
        checks++;
        if (pulse_cnt != 1) begin
            fails++;
            $display("FAIL R2 pulse count: actual %0d expected 1", pulse_cnt);
        end
        // R6: a second request after start still pulses, but running never drops.
        phase = "R6";
        req_n = 1'b1; ticks(4);
        req_n = 1'b0; ticks(8);
        checks++;
        if (pulse_cnt != 2) begin
            fails++;
            $display("FAIL R2 second request pulse count: actual %0d expected 2", pulse_cnt);
        end
        req_n = 1'b1; ticks(4);
        // R3: reset clears the operating mode.
        phase = "R3";
        rst = 1'b1; ticks(3);
        rst = 1'b0; ticks(3);
        // R4: synchronous start alone.
        phase = "R4";
        sync_a = 1'b1; tick();
        sync_a = 1'b0; ticks(6);
        checks++;
        if (a_run !== 1'b1 || b_run !== 1'b0) begin
            fails++;
            $display("FAIL R4 run after sync start: actual %b/%b expected 1/0", a_run, b_run);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #20000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule